// File: doc/BRIEF.md
# Lane alignment sequence generator

This block produces the alignment sequence that one transmit lane of a serial converter link sends between code-group synchronization and user data. Each clock it emits one octet and a flag that marks the octet as a control character. Both go to a downstream 8b/10b encoder. The sequence is a run of multiframes. Each multiframe is bracketed by start and end control characters. The second multiframe carries a packed block of link parameters followed by an additive checksum. Every other octet comes from an incrementing filler counter. Once the last multiframe ends, the block hands the lane to user data.

The sequence starts when the receiver releases its sync request. The sync request input is active low. If alignment is disabled, the release goes straight to user data. A debug loop bit keeps the lane repeating plain multiframes with no parameter block. A relink pulse forces comma characters until the receiver's next release. If the sync request is asserted again during the sequence or during user data, the block aborts to idle.

States and transitions:
- ST_IDLE: outputs zero. On release it moves to ST_ILAS, or to ST_DATA when alignment is disabled.
- ST_KCHAR: sends commas. It is entered from any state on relink and leaves on release, the same way ST_IDLE does.
- ST_ILAS: sends multiframes. It moves to ST_DATA after the final end character. A request reasserted here moves it to ST_IDLE.
- ST_DATA: passes user octets through. A reasserted request moves it to ST_IDLE.

Relink has the highest priority. The abort comes next, then release.

Top module: `lane_align_gen`

## Requirements
- R1: A rising edge of `sync_req_n` seen in ST_IDLE or ST_KCHAR starts the sequence. The first start character appears in the cycle after the edge is sampled. With `align_en` low, the same edge makes `user_valid` high in that next cycle instead.
- R2: The first octet of every multiframe is 8'h1C and the last is 8'h7C, both with `tx_is_ctrl`=1.
- R3: The sequence is 4 multiframes long. When `cfg_subclass` is 0 and `ext_mf` is at least 3, it is `ext_mf`+1 multiframes instead, up to 256. A smaller `ext_mf`, or a nonzero subclass, keeps 4.
- R4: Multiframe index 1 (the second) holds, in this order: 8'h1C, then 8'h9C with ctrl=1, then 14 parameter octets with ctrl=0, then filler, then 8'h7C.
- R5: The parameter octets are packed as follows (bit 7 first).
  - p0 = dev_id.
  - p1 = {adj_steps, bank_id}.
  - p2 = {0, adj_dir, phase_req, lane_id}.
  - p3 = {scr_on, 00, lanes}.
  - p4 = octets_pf.
  - p5 = {000, frames_pmf}.
  - p6 = conv.
  - p7 = {ctl_bits, 0, res}.
  - p8 = {subclass, bits_ps}.
  - p9 = {version, samples}.
  - p10 = {hidens, 00, ctl_words}.
  - p11 and p12 are 0.
- R6: p13 is the sum of p0 to p12 modulo 256.
- R7: Every other octet between the framing characters is the filler value, with ctrl=0. The filler value equals the number of cycles since the sequence began, modulo 256, and starts at 0 on every entry.
- R8: `ilas_done` pulses for one cycle, on the final end character. From the next cycle `user_valid` is 1 and `tx_octet` equals `user_octet`, with ctrl=0.
- R9: While `loop_en` is 1, multiframes contain only start, filler and end characters, and the sequence never exits. Once it is cleared, the sequence exits at the end of the next multiframe whose index has reached the count in R3.
- R10: A `relink` pulse makes the lane send 8'hBC with ctrl=1 from the next cycle until a release starts a new sequence.
- R11: After reset, and in the cycle after `sync_req_n` is sampled low in ST_ILAS or ST_DATA, outputs are idle: octet 0, ctrl 0, `user_valid` 0.
- R12: A multiframe holds (`cfg_octets_pf`+1)×(`cfg_frames_pmf`+1) octets. This product must be at least 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one octet per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_req_n | input | 1 | Receiver sync request, active low |
| align_en | input | 1 | Enables the alignment sequence |
| loop_en | input | 1 | Debug loop, stays in alignment |
| relink | input | 1 | Forces comma characters until the next release |
| ext_mf | input | 8 | Multiframe count minus one, used in subclass 0 |
| cfg_dev_id | input | 8 | Device identifier |
| cfg_adj_steps | input | 4 | Adjustment step count |
| cfg_bank_id | input | 4 | Bank identifier |
| cfg_adj_dir | input | 1 | Adjustment direction |
| cfg_phase_req | input | 1 | Phase adjust request |
| cfg_lane_id | input | 5 | Lane identifier |
| cfg_scr_on | input | 1 | Scrambling indicator (not applied here) |
| cfg_lanes | input | 5 | Lanes per link, encoded |
| cfg_octets_pf | input | 8 | Octets per frame minus one |
| cfg_frames_pmf | input | 5 | Frames per multiframe minus one |
| cfg_conv | input | 8 | Converter count, encoded |
| cfg_ctl_bits | input | 2 | Control bits per sample |
| cfg_res | input | 5 | Converter resolution, encoded |
| cfg_subclass | input | 3 | Subclass version |
| cfg_bits_ps | input | 5 | Total bits per sample, encoded |
| cfg_version | input | 3 | Link standard version |
| cfg_samples | input | 5 | Samples per converter per frame, encoded |
| cfg_hidens | input | 1 | High-density format |
| cfg_ctl_words | input | 5 | Control words per frame |
| user_octet | input | 8 | User data octet |
| tx_octet | output | 8 | Octet to the encoder |
| tx_is_ctrl | output | 1 | Octet is a control character |
| ilas_done | output | 1 | Final end character of the sequence |
| user_valid | output | 1 | User data phase active |

## Verification
The interesting collision is the completion pulse meeting an abort. The test drives `sync_req_n` low in exactly the cycle that carries the final end character. The bench expects `ilas_done` high in that cycle, then idle outputs with `user_valid` never rising. A second collision occurs in loop mode, where clearing the loop bit in the same multiframe the counter has saturated must let that multiframe end with the completion pulse. Filler wrap-around inside a long subclass-0 run is judged against the cycle count since entry.

// File: rtl/lag_pkg.sv
package lag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_KCHAR = 2'd1,
        ST_ILAS  = 2'd2,
        ST_DATA  = 2'd3
    } lag_state_e;

    localparam logic [7:0] SYM_MF_BEGIN = 8'h1C;
    localparam logic [7:0] SYM_MF_END   = 8'h7C;
    localparam logic [7:0] SYM_CFG_MARK = 8'h9C;
    localparam logic [7:0] SYM_COMMA    = 8'hBC;

    localparam int CFG_OCTETS    = 14;
    localparam int CFG_FIRST_POS = 2;

endpackage

// File: rtl/lag_cfg_pack.sv
module lag_cfg_pack
    import lag_pkg::*;
(
    input  logic [7:0] dev_id,
    input  logic [3:0] adj_steps,
    input  logic [3:0] bank_id,
    input  logic       adj_dir,
    input  logic       phase_req,
    input  logic [4:0] lane_id,
    input  logic       scr_on,
    input  logic [4:0] lanes,
    input  logic [7:0] octets_pf,
    input  logic [4:0] frames_pmf,
    input  logic [7:0] conv,
    input  logic [1:0] ctl_bits,
    input  logic [4:0] res,
    input  logic [2:0] subclass,
    input  logic [4:0] bits_ps,
    input  logic [2:0] version,
    input  logic [4:0] samples,
    input  logic       hidens,
    input  logic [4:0] ctl_words,
    output logic [CFG_OCTETS-1:0][7:0] cfg_oct
);

    localparam int BODY_N = CFG_OCTETS - 1;

    logic [BODY_N-1:0][7:0] body;
    logic [7:0]             csum;

    always_comb begin
        body[0]  = dev_id;
        body[1]  = {adj_steps, bank_id};
        body[2]  = {1'b0, adj_dir, phase_req, lane_id};
        body[3]  = {scr_on, 2'b00, lanes};
        body[4]  = octets_pf;
        body[5]  = {3'b000, frames_pmf};
        body[6]  = conv;
        body[7]  = {ctl_bits, 1'b0, res};
        body[8]  = {subclass, bits_ps};
        body[9]  = {version, samples};
        body[10] = {hidens, 2'b00, ctl_words};
        body[11] = 8'h00;
        body[12] = 8'h00;
    end

    always_comb begin
        csum = 8'h00;
        for (int i = 0; i < BODY_N; i++) begin
            csum = csum + body[i];
        end
    end

    assign cfg_oct = {csum, body};

endmodule

// File: rtl/lag_fill_ctr.sv
module lag_fill_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (run) begin
            value <= value + W'(1);
        end else begin
            value <= '0;
        end
    end

endmodule

// File: rtl/lag_seq_fsm.sv
module lag_seq_fsm
    import lag_pkg::*;
#(
    parameter int POS_W = 14,
    parameter int MF_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic             align_en,
    input  logic             loop_en,
    input  logic             relink,
    input  logic [POS_W-1:0] mf_len,
    input  logic [MF_W-1:0]  mf_last,
    output lag_state_e       state,
    output logic [POS_W-1:0] oct_idx,
    output logic [MF_W-1:0]  mf_idx,
    output logic             mf_end,
    output logic             done
);

    lag_state_e state_n;
    logic       sync_q;
    logic       release_seen;
    logic       final_mf;
    logic       stay_ilas;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b1;
        end else begin
            sync_q <= sync_n;
        end
    end

    assign release_seen = sync_n & ~sync_q;
    assign mf_end       = (oct_idx == (mf_len - POS_W'(1)));
    assign final_mf     = mf_end && (mf_idx == mf_last) && !loop_en;
    assign done         = (state == ST_ILAS) && final_mf;

    always_comb begin
        state_n = state;
        if (relink) begin
            state_n = ST_KCHAR;
        end else begin
            unique case (state)
                ST_IDLE, ST_KCHAR: begin
                    if (release_seen) begin
                        state_n = align_en ? ST_ILAS : ST_DATA;
                    end
                end
                ST_ILAS: begin
                    if (!sync_n) begin
                        state_n = ST_IDLE;
                    end else if (final_mf) begin
                        state_n = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (!sync_n) begin
                        state_n = ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    assign stay_ilas = (state == ST_ILAS) && (state_n == ST_ILAS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oct_idx <= '0;
            mf_idx  <= '0;
        end else if (stay_ilas) begin
            if (mf_end) begin
                oct_idx <= '0;
                if (mf_idx != mf_last) begin
                    mf_idx <= mf_idx + MF_W'(1);
                end
            end else begin
                oct_idx <= oct_idx + POS_W'(1);
            end
        end else begin
            oct_idx <= '0;
            mf_idx  <= '0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ILAS || state == ST_DATA) && !sync_n && !relink) |=> (state == ST_IDLE));  // R11

    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ILAS && loop_en && sync_n && !relink) |=> (state == ST_ILAS));  // R9

    AST_MF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ILAS) |-> (mf_idx <= mf_last));  // R3

    AST_RELINK_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        relink |=> (state == ST_KCHAR));  // R10

endmodule

// File: rtl/lane_align_gen.sv
module lane_align_gen
    import lag_pkg::*;
#(
    parameter int F_W    = 8,
    parameter int K_W    = 5,
    parameter int MF_W   = 8,
    parameter int DEF_MF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_req_n,
    input  logic            align_en,
    input  logic            loop_en,
    input  logic            relink,
    input  logic [MF_W-1:0] ext_mf,
    input  logic [7:0]      cfg_dev_id,
    input  logic [3:0]      cfg_adj_steps,
    input  logic [3:0]      cfg_bank_id,
    input  logic            cfg_adj_dir,
    input  logic            cfg_phase_req,
    input  logic [4:0]      cfg_lane_id,
    input  logic            cfg_scr_on,
    input  logic [4:0]      cfg_lanes,
    input  logic [F_W-1:0]  cfg_octets_pf,
    input  logic [K_W-1:0]  cfg_frames_pmf,
    input  logic [7:0]      cfg_conv,
    input  logic [1:0]      cfg_ctl_bits,
    input  logic [4:0]      cfg_res,
    input  logic [2:0]      cfg_subclass,
    input  logic [4:0]      cfg_bits_ps,
    input  logic [2:0]      cfg_version,
    input  logic [4:0]      cfg_samples,
    input  logic            cfg_hidens,
    input  logic [4:0]      cfg_ctl_words,
    input  logic [7:0]      user_octet,
    output logic [7:0]      tx_octet,
    output logic            tx_is_ctrl,
    output logic            ilas_done,
    output logic            user_valid
);

    localparam int POS_W = F_W + K_W + 1;
    localparam logic [MF_W-1:0] DEF_LAST = MF_W'(DEF_MF - 1);

    lag_state_e                  state;
    logic [POS_W-1:0]            oct_idx;
    logic [MF_W-1:0]             mf_idx;
    logic                        mf_end;
    logic                        done;
    logic [POS_W-1:0]            f_len;
    logic [POS_W-1:0]            k_len;
    logic [POS_W-1:0]            mf_len;
    logic [MF_W-1:0]             mf_last;
    logic [7:0]                  fill;
    logic [CFG_OCTETS-1:0][7:0]  cfg_oct;
    logic                        cfg_mf;
    logic                        cfg_zone;
    logic [7:0]                  cfg_byte;

    // Multiframe geometry and length mode
    assign f_len   = POS_W'(cfg_octets_pf) + POS_W'(1);
    assign k_len   = POS_W'(cfg_frames_pmf) + POS_W'(1);
    assign mf_len  = f_len * k_len;
    assign mf_last = ((cfg_subclass == 3'd0) && (ext_mf >= DEF_LAST)) ? ext_mf : DEF_LAST;

    lag_seq_fsm #(
        .POS_W (POS_W),
        .MF_W  (MF_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_req_n),
        .align_en (align_en),
        .loop_en  (loop_en),
        .relink   (relink),
        .mf_len   (mf_len),
        .mf_last  (mf_last),
        .state    (state),
        .oct_idx  (oct_idx),
        .mf_idx   (mf_idx),
        .mf_end   (mf_end),
        .done     (done)
    );

    lag_fill_ctr #(
        .W (8)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_ILAS),
        .value (fill)
    );

    lag_cfg_pack u_pack (
        .dev_id     (cfg_dev_id),
        .adj_steps  (cfg_adj_steps),
        .bank_id    (cfg_bank_id),
        .adj_dir    (cfg_adj_dir),
        .phase_req  (cfg_phase_req),
        .lane_id    (cfg_lane_id),
        .scr_on     (cfg_scr_on),
        .lanes      (cfg_lanes),
        .octets_pf  (8'(cfg_octets_pf)),
        .frames_pmf (5'(cfg_frames_pmf)),
        .conv       (cfg_conv),
        .ctl_bits   (cfg_ctl_bits),
        .res        (cfg_res),
        .subclass   (cfg_subclass),
        .bits_ps    (cfg_bits_ps),
        .version    (cfg_version),
        .samples    (cfg_samples),
        .hidens     (cfg_hidens),
        .ctl_words  (cfg_ctl_words),
        .cfg_oct    (cfg_oct)
    );

    // Parameter block position inside the second multiframe
    assign cfg_mf   = (mf_idx == MF_W'(1)) && !loop_en;
    assign cfg_zone = cfg_mf && (oct_idx >= POS_W'(CFG_FIRST_POS))
                      && (oct_idx < POS_W'(CFG_FIRST_POS + CFG_OCTETS));

    always_comb begin
        cfg_byte = 8'h00;
        for (int i = 0; i < CFG_OCTETS; i++) begin
            if (oct_idx == POS_W'(CFG_FIRST_POS + i)) begin
                cfg_byte = cfg_oct[i];
            end
        end
    end

    // Output process
    always_comb begin
        tx_octet   = 8'h00;
        tx_is_ctrl = 1'b0;
        ilas_done  = 1'b0;
        user_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                tx_octet   = 8'h00;
                tx_is_ctrl = 1'b0;
            end
            ST_KCHAR: begin
                tx_octet   = SYM_COMMA;
                tx_is_ctrl = 1'b1;
            end
            ST_ILAS: begin
                ilas_done = done;
                if (oct_idx == '0) begin
                    tx_octet   = SYM_MF_BEGIN;
                    tx_is_ctrl = 1'b1;
                end else if (mf_end) begin
                    tx_octet   = SYM_MF_END;
                    tx_is_ctrl = 1'b1;
                end else if (cfg_mf && (oct_idx == POS_W'(1))) begin
                    tx_octet   = SYM_CFG_MARK;
                    tx_is_ctrl = 1'b1;
                end else if (cfg_zone) begin
                    tx_octet   = cfg_byte;
                end else begin
                    tx_octet   = fill;
                end
            end
            ST_DATA: begin
                tx_octet   = user_octet;
                user_valid = 1'b1;
            end
        endcase
    end

    AST_START_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ILAS && oct_idx == '0) |-> (tx_is_ctrl && tx_octet == SYM_MF_BEGIN));  // R2

    AST_FILL_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ILAS && mf_idx == '0 && oct_idx == '0) |-> (fill == 8'h00));  // R7

    AST_DATA_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        user_valid |-> (!tx_is_ctrl && !ilas_done));  // R8

    AST_DONE_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ilas_done && sync_req_n && !relink) |=> user_valid);  // R8

endmodule

// File: tb/sim_lane_align_gen.sv
module sim_lane_align_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_req_n = 1'b0;
    logic       align_en = 1'b1;
    logic       loop_en = 1'b0;
    logic       relink = 1'b0;
    logic [7:0] ext_mf = 8'd0;
    logic [7:0] c_dev = 8'h12;
    logic [3:0] c_adjs = 4'h3;
    logic [3:0] c_bank = 4'h5;
    logic       c_adjd = 1'b0;
    logic       c_phr = 1'b1;
    logic [4:0] c_lane = 5'd2;
    logic       c_scr = 1'b1;
    logic [4:0] c_lanes = 5'd3;
    logic [7:0] c_f = 8'd3;
    logic [4:0] c_k = 5'd4;
    logic [7:0] c_conv = 8'd1;
    logic [1:0] c_cs = 2'd1;
    logic [4:0] c_res = 5'd13;
    logic [2:0] c_sub = 3'd1;
    logic [4:0] c_bps = 5'd15;
    logic [2:0] c_ver = 3'd1;
    logic [4:0] c_smp = 5'd0;
    logic       c_hd = 1'b0;
    logic [4:0] c_cw = 5'd0;
    logic [7:0] user_octet = 8'h00;
    logic [7:0] tx_octet;
    logic       tx_is_ctrl;
    logic       ilas_done;
    logic       user_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [10:0] q_val[$];
    string       q_tag[$];
    logic [7:0]  exp_cfg[14];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lane_align_gen u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_req_n     (sync_req_n),
        .align_en       (align_en),
        .loop_en        (loop_en),
        .relink         (relink),
        .ext_mf         (ext_mf),
        .cfg_dev_id     (c_dev),
        .cfg_adj_steps  (c_adjs),
        .cfg_bank_id    (c_bank),
        .cfg_adj_dir    (c_adjd),
        .cfg_phase_req  (c_phr),
        .cfg_lane_id    (c_lane),
        .cfg_scr_on     (c_scr),
        .cfg_lanes      (c_lanes),
        .cfg_octets_pf  (c_f),
        .cfg_frames_pmf (c_k),
        .cfg_conv       (c_conv),
        .cfg_ctl_bits   (c_cs),
        .cfg_res        (c_res),
        .cfg_subclass   (c_sub),
        .cfg_bits_ps    (c_bps),
        .cfg_version    (c_ver),
        .cfg_samples    (c_smp),
        .cfg_hidens     (c_hd),
        .cfg_ctl_words  (c_cw),
        .user_octet     (user_octet),
        .tx_octet       (tx_octet),
        .tx_is_ctrl     (tx_is_ctrl),
        .ilas_done      (ilas_done),
        .user_valid     (user_valid)
    );

    // Monitor: pops one expected item per cycle at the falling edge
    always @(negedge clk) begin
        if (q_val.size() > 0) begin
            logic [10:0] e;
            logic [10:0] a;
            string t;
            e = q_val.pop_front();
            t = q_tag.pop_front();
            a = {tx_octet, tx_is_ctrl, ilas_done, user_valid};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: act oct=%h ctrl=%b done=%b valid=%b exp oct=%h ctrl=%b done=%b valid=%b",
                         t, a[10:3], a[2], a[1], a[0], e[10:3], e[2], e[1], e[0]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input logic [7:0] o, input logic c, input logic d, input logic v, input string t);
        q_val.push_back({o, c, d, v});
        q_tag.push_back(t);
    endtask

    // R5, R6 packing from the requirement text
    task automatic build_cfg();
        logic [7:0] s;
        exp_cfg[0]  = c_dev;
        exp_cfg[1]  = {c_adjs, c_bank};
        exp_cfg[2]  = {1'b0, c_adjd, c_phr, c_lane};
        exp_cfg[3]  = {c_scr, 2'b00, c_lanes};
        exp_cfg[4]  = c_f;
        exp_cfg[5]  = {3'b000, c_k};
        exp_cfg[6]  = c_conv;
        exp_cfg[7]  = {c_cs, 1'b0, c_res};
        exp_cfg[8]  = {c_sub, c_bps};
        exp_cfg[9]  = {c_ver, c_smp};
        exp_cfg[10] = {c_hd, 2'b00, c_cw};
        exp_cfg[11] = 8'h00;
        exp_cfg[12] = 8'h00;
        s = 8'h00;
        for (int i = 0; i < 13; i++) s = s + exp_cfg[i];
        exp_cfg[13] = s;
    endtask

    task automatic idle_cycles(input int n, input string t);
        for (int i = 0; i < n; i++) begin
            tick();
            push(8'h00, 1'b0, 1'b0, 1'b0, t);
        end
    endtask

    task automatic start_rise(input string t);
        tick();
        sync_req_n = 1'b1;
        push(8'h00, 1'b0, 1'b0, 1'b0, t);
    endtask

    task automatic ilas_run(input int nmf, input int len, input int loop_mfs, input int abort_i, input string t);
        build_cfg();
        for (int i = 0; i < nmf * len; i++) begin
            int mf;
            int oc;
            bit inloop;
            logic [7:0] eo;
            logic ec;
            tick();
            mf = i / len;
            oc = i % len;
            if (loop_mfs > 0 && i == loop_mfs * len) loop_en = 1'b0;
            if (i == abort_i) sync_req_n = 1'b0;
            inloop = (mf < loop_mfs);
            if (oc == 0) begin
                eo = 8'h1C; ec = 1'b1;              // R2
            end else if (oc == len - 1) begin
                eo = 8'h7C; ec = 1'b1;              // R2
            end else if (mf == 1 && !inloop && oc == 1) begin
                eo = 8'h9C; ec = 1'b1;              // R4
            end else if (mf == 1 && !inloop && oc >= 2 && oc <= 15) begin
                eo = exp_cfg[oc - 2]; ec = 1'b0;    // R5 R6
            end else begin
                eo = 8'(i % 256); ec = 1'b0;        // R7
            end
            push(eo, ec, (i == nmf * len - 1), 1'b0, t);
            if (i == abort_i) break;
        end
    endtask

    task automatic data_run(input int n, input string t);
        for (int i = 0; i < n; i++) begin
            tick();
            user_octet = 8'(8'h30 + i * 7);
            push(user_octet, 1'b0, 1'b0, 1'b1, t);
        end
    endtask

    task automatic leave_data(input string t);
        tick();
        sync_req_n = 1'b0;
        push(user_octet, 1'b0, 1'b0, 1'b1, t);
        idle_cycles(2, t);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        idle_cycles(2, "R11 reset idle");

        // Default length, nonzero subclass ignores ext_mf
        ext_mf = 8'd9;
        start_rise("R1 release");
        ilas_run(4, 20, 0, -1, "R3 R4 default run");
        data_run(3, "R8 user data");
        leave_data("R11 abort from data");

        // Subclass 0 extension, long multiframe, filler wrap, checksum overflow
        c_sub = 3'd0; ext_mf = 8'd5; c_f = 8'd7; c_k = 5'd7;
        c_dev = 8'hF1; c_adjs = 4'hE; c_bank = 4'hD; c_adjd = 1'b1; c_phr = 1'b1;
        c_lane = 5'h1F; c_scr = 1'b1; c_lanes = 5'h1E; c_conv = 8'hFF; c_cs = 2'd3;
        c_res = 5'h1F; c_bps = 5'h1F; c_ver = 3'd7; c_smp = 5'h1F; c_hd = 1'b1; c_cw = 5'h1F;
        start_rise("R1 release sc0");
        ilas_run(6, 64, 0, -1, "R3 R6 R7 R12 extended run");
        data_run(2, "R8 after extended");
        leave_data("R11 leave");

        // Subclass 0 with small extension stays at 4, minimum length 17
        ext_mf = 8'd1; c_f = 8'd16; c_k = 5'd0;
        start_rise("R1 release min");
        ilas_run(4, 17, 0, -1, "R3 R12 minimum multiframe");
        data_run(1, "R8 after min");
        leave_data("R11 leave min");

        // Alignment disabled
        c_sub = 3'd1; c_f = 8'd3; c_k = 5'd4; align_en = 1'b0;
        start_rise("R1 bypass release");
        data_run(2, "R1 bypass to data");
        leave_data("R11 leave bypass");
        align_en = 1'b1;

        // Loop mode then clear
        loop_en = 1'b1;
        start_rise("R9 release with loop");
        ilas_run(7, 20, 6, -1, "R9 loop run");
        data_run(1, "R9 exit to data");

        // Relink from data phase
        tick();
        relink = 1'b1;
        push(user_octet, 1'b0, 1'b0, 1'b1, "R10 relink cycle");
        tick();
        relink = 1'b0;
        sync_req_n = 1'b0;
        push(8'hBC, 1'b1, 1'b0, 1'b0, "R10 comma");
        tick();
        push(8'hBC, 1'b1, 1'b0, 1'b0, "R10 comma");
        tick();
        sync_req_n = 1'b1;
        push(8'hBC, 1'b1, 1'b0, 1'b0, "R10 comma release");
        ilas_run(4, 20, 0, -1, "R10 ilas after relink");
        data_run(1, "R10 data");
        leave_data("R11 leave relink");

        // Abort in the middle, then a clean restart
        start_rise("R11 release");
        ilas_run(4, 20, 0, 45, "R11 mid abort");
        idle_cycles(2, "R11 idle after abort");
        start_rise("R7 restart release");
        ilas_run(4, 20, 0, -1, "R7 restart from zero");
        data_run(1, "R8 restart data");
        leave_data("R11 leave restart");

        // Abort on the completion cycle
        start_rise("R8 corner release");
        ilas_run(4, 20, 0, 79, "R8 R11 done with abort");
        idle_cycles(3, "R8 R11 no data after abort");

        @(negedge clk);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule